// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps calendar time (seconds, minutes, hours, day of month, month, year past 2000 and weekday) from a slow enable pulse that marks each cycle of a 32.768 kHz oscillator. A prescaler turns a fixed number of those pulses into one second. The calendar advances on that second, taking the length of each month into account. A year is a leap year when it is divisible by 4. Every field is read and written as a BCD byte through a small address/data register port. The hour can be viewed and written in a 24-hour or a 12-hour form with a PM flag.

On each second the block can raise a one-cycle periodic pulse, on every second or only when seconds, minutes or hours roll over. It can also raise a one-cycle alarm pulse when the time reaches a programmed date and time. Both pulses are meant for an interrupt controller. A signed trim value shortens or lengthens one second per trim period, which corrects oscillator drift. Reading the seconds register freezes a copy of all the other time fields, so a read of several bytes stays coherent across a rollover.

The register port has no back-pressure. A write takes effect at the clock edge where it is presented. A read returns its byte on `bus_rdata` in the cycle after `bus_rd` is sampled, and the value holds until the next read.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the control byte is 0x00 (stopped), the time is 00:00:00, day 01, month 01, year 00, weekday 0, trim 0x0000, and the alarm is 00:00:00 on day 01, month 01, year 04. Neither pulse output is active.
- R2: The control byte is at address 0: bit 0 runs the clock, bit 1 enables the alarm, bit 2 selects 12-hour view, and bits 4:3 select the periodic event. Bits 7:5 are not stored and read as 0.
- R3: While running, the seconds count advances once per TICKS_PER_SEC enable pulses. Clearing bit 0 freezes the time and the partial-second phase, and setting it again resumes from that phase.
- R4: The calendar rolls seconds→minutes→hours→day→month→year, with 30-day months 4, 6, 9 and 11, February 29 days when year mod 4 is 0 and 28 days otherwise, year 99 wrapping to 00, and the weekday counting 0..6 at each midnight.
- R5: Address map: 1 sec, 2 min, 3 hour, 4 day, 5 month, 6 year, 7 weekday; 8..13 alarm sec, min, hour, day, month, year; 14 trim high byte, 15 trim low byte. A read returns its byte one cycle after `bus_rd`.
- R6: With bit 2 set, an hour reads as BCD(h mod 12 + 1), with bit 7 set when the 24-hour value h is 12 or more. This applies to the time and to the alarm.
- R7: With bit 2 set, a written hour becomes min(BCD(bits 5:0), 12), raised to at least 1, then plus 11 when bit 7 is set or minus 1 when it is clear. With bit 2 clear, bits 5:0 are a plain BCD hour capped at 23.
- R8: Seconds and minutes writes ignore bit 7 and are capped at 59. A written month of 0 becomes 1, and month is capped at 12. Day is held in 1..31, year is capped at 99, and weekday is capped at 6.
- R9: Periodic select 0 pulses on every second. Select 1 pulses when seconds wrap to 0. Select 2 pulses when seconds and minutes wrap to 0. Select 3 pulses when the hour also wraps to 0. The pulse lasts one cycle and comes with the updated time.
- R10: With the alarm enabled, a one-cycle alarm pulse comes with the second at which seconds, minutes, hour, day, month and year all equal the alarm fields. No pulse comes when the alarm is disabled.
- R11: The trim is a signed 16-bit count of enable pulses. The second that starts after TRIM_FIRST_S seconds from reset, and then one second in every TRIM_PERIOD_S, lasts TICKS_PER_SEC minus the trim pulses.
- R12: Reading seconds returns the live value and captures every other time field. Reads of addresses 2..7 return that captured copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per oscillator cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| periodic_pulse | output | 1 | One-cycle periodic event |
| alarm_pulse | output | 1 | One-cycle alarm event |

## Verification
A corrupted prescaler count or trim counter shows up as a second boundary that lands at the wrong enable pulse. The bench detects this within one second by reading the seconds register one pulse before and one pulse after the expected boundary. A wrong calendar field becomes visible at the next rollover of that field, when the BCD value read back or the presence of a periodic or alarm pulse disagrees with the expected value in that same second. A stale or torn snapshot appears at once, on the first read of a field captured before a rollover.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
    logic [2:0] wd;
  } rtc_time_t;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] t, o;
    t = v / 7'd10;
    o = v % 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] b);
    return {4'b0, b[7:4]} * 8'd10 + {4'b0, b[3:0]};
  endfunction

  function automatic logic [6:0] clampv(input logic [7:0] v, input logic [7:0] lo,
                                        input logic [7:0] hi);
    logic [7:0] r;
    r = (v < lo) ? lo : ((v > hi) ? hi : v);
    return r[6:0];
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

  // field index: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year, 6 weekday
  function automatic logic [6:0] get_f(input rtc_time_t t, input logic [2:0] idx);
    case (idx)
      3'd0:    return {1'b0, t.sc};
      3'd1:    return {1'b0, t.mn};
      3'd2:    return {2'b0, t.hr};
      3'd3:    return {2'b0, t.day};
      3'd4:    return {3'b0, t.mon};
      3'd5:    return t.yr;
      default: return {4'b0, t.wd};
    endcase
  endfunction

  function automatic rtc_time_t set_f(input rtc_time_t t, input logic [2:0] idx,
                                      input logic [6:0] v);
    rtc_time_t r;
    r = t;
    case (idx)
      3'd0:    r.sc  = v[5:0];
      3'd1:    r.mn  = v[5:0];
      3'd2:    r.hr  = v[4:0];
      3'd3:    r.day = v[4:0];
      3'd4:    r.mon = v[3:0];
      3'd5:    r.yr  = v;
      default: r.wd  = v[2:0];
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int TRIM_PERIOD_S = 3600,
  parameter int TRIM_FIRST_S  = 1800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        tick_en,
  input  logic [15:0] trim,
  output logic        sec_tick
);
  localparam int CW = $clog2(TICKS_PER_SEC + 32769) + 1;
  localparam int TW = $clog2(TRIM_PERIOD_S + 1);

  logic [CW-1:0]        cnt_q;
  logic [TW-1:0]        trim_q;
  logic                 armed_q;
  logic signed [CW:0]   lim_raw;
  logic [CW-1:0]        lim;

  always_comb begin
    lim_raw = (CW+1)'(TICKS_PER_SEC);
    if (armed_q) lim_raw = lim_raw - (CW+1)'($signed(trim));
    if (lim_raw[CW] || lim_raw == '0) lim = CW'(1);
    else                              lim = lim_raw[CW-1:0];
  end

  assign sec_tick = run && tick_en && (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trim_q  <= TW'(TRIM_FIRST_S);
      armed_q <= 1'b0;
    end else if (run && tick_en) begin
      cnt_q <= sec_tick ? '0 : cnt_q + CW'(1);
      if (sec_tick) begin
        if (trim_q == TW'(1)) begin
          trim_q  <= TW'(TRIM_PERIOD_S);
          armed_q <= 1'b1;
        end else begin
          trim_q  <= trim_q - TW'(1);
          armed_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_tick,
  input  logic [6:0] wr_hit,
  input  logic [6:0] wr_val,
  output rtc_time_t cur_o,
  output rtc_time_t inc_o
);
  rtc_time_t cur_q, inc, nxt;

  always_comb begin
    inc = cur_q;
    if (cur_q.sc != 6'd59) inc.sc = cur_q.sc + 6'd1;
    else begin
      inc.sc = '0;
      if (cur_q.mn != 6'd59) inc.mn = cur_q.mn + 6'd1;
      else begin
        inc.mn = '0;
        if (cur_q.hr != 5'd23) inc.hr = cur_q.hr + 5'd1;
        else begin
          inc.hr = '0;
          inc.wd = (cur_q.wd >= 3'd6) ? 3'd0 : cur_q.wd + 3'd1;
          if (cur_q.day < month_days(cur_q.mon, cur_q.yr)) inc.day = cur_q.day + 5'd1;
          else begin
            inc.day = 5'd1;
            if (cur_q.mon < 4'd12) inc.mon = cur_q.mon + 4'd1;
            else begin
              inc.mon = 4'd1;
              inc.yr  = (cur_q.yr >= 7'd99) ? 7'd0 : cur_q.yr + 7'd1;
            end
          end
        end
      end
    end
    nxt = sec_tick ? inc : cur_q;
    for (int i = 0; i < 7; i++)
      if (wr_hit[i]) nxt = set_f(nxt, 3'(i), wr_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '{yr: 7'd0, mon: 4'd1, day: 5'd1, hr: 5'd0, mn: 6'd0, sc: 6'd0, wd: 3'd0};
    else        cur_q <= nxt;
  end

  assign cur_o = cur_q;
  assign inc_o = inc;
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int TRIM_PERIOD_S = 3600,
  parameter int TRIM_FIRST_S  = 1800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       periodic_pulse,
  output logic       alarm_pulse
);
  localparam int NCAL = 7;

  logic [4:0]  ctrl_q;
  logic [15:0] trim_q;
  rtc_time_t   al_q, snap_q, cal_cur, cal_inc;
  logic [7:0]  rdata_q, rd_mux;
  logic        per_q, alm_q, sec_tick, per_hit, al_match;
  logic [NCAL-1:0] cal_hit;
  logic [6:0]  cal_val, al_val;

  function automatic logic [6:0] hour_in(input logic [7:0] v, input logic m12);
    logic [7:0] b;
    logic [6:0] c;
    b = from_bcd({2'b00, v[5:0]});
    if (!m12) return clampv(b, 8'd0, 8'd23);
    c = clampv(b, 8'd1, 8'd12);
    return v[7] ? c + 7'd11 : c - 7'd1;
  endfunction

  function automatic logic [7:0] hour_out(input logic [4:0] h, input logic m12);
    logic [4:0] h12;
    logic [7:0] b;
    if (!m12) return to_bcd({2'b0, h});
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    b   = to_bcd({2'b0, h12 + 5'd1});
    return {h >= 5'd12, b[6:0]};
  endfunction

  function automatic logic [6:0] field_in(input logic [2:0] idx, input logic [7:0] v,
                                          input logic m12);
    case (idx)
      3'd0, 3'd1: return clampv(from_bcd({1'b0, v[6:0]}), 8'd0, 8'd59);
      3'd2:       return hour_in(v, m12);
      3'd3:       return clampv(from_bcd(v), 8'd1, 8'd31);
      3'd4:       return clampv(from_bcd(v), 8'd1, 8'd12);
      3'd5:       return clampv(from_bcd(v), 8'd0, 8'd99);
      default:    return clampv(from_bcd(v), 8'd0, 8'd6);
    endcase
  endfunction

  function automatic logic [7:0] field_out(input logic [2:0] idx, input rtc_time_t t,
                                           input logic m12);
    if (idx == 3'd2) return hour_out(t.hr, m12);
    return to_bcd(get_f(t, idx));
  endfunction

  bcd_rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .TRIM_PERIOD_S(TRIM_PERIOD_S), .TRIM_FIRST_S(TRIM_FIRST_S)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .tick_en(tick_en), .trim(trim_q),
    .sec_tick(sec_tick)
  );

  for (genvar gi = 0; gi < NCAL; gi++) begin : g_hit
    assign cal_hit[gi] = bus_wr && (bus_addr == 4'(gi + 1));
  end

  assign cal_val = field_in(3'(bus_addr - 4'd1), bus_wdata, ctrl_q[2]);
  assign al_val  = field_in(3'(bus_addr - 4'd8), bus_wdata, ctrl_q[2]);

  bcd_rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_hit(cal_hit), .wr_val(cal_val),
    .cur_o(cal_cur), .inc_o(cal_inc)
  );

  always_comb begin
    case (ctrl_q[4:3])
      2'd0:    per_hit = 1'b1;
      2'd1:    per_hit = (cal_inc.sc == '0);
      2'd2:    per_hit = (cal_inc.sc == '0) && (cal_inc.mn == '0);
      default: per_hit = (cal_inc.sc == '0) && (cal_inc.mn == '0) && (cal_inc.hr == '0);
    endcase
    al_match = (cal_inc.sc == al_q.sc) && (cal_inc.mn == al_q.mn) && (cal_inc.hr == al_q.hr)
            && (cal_inc.day == al_q.day) && (cal_inc.mon == al_q.mon) && (cal_inc.yr == al_q.yr);
  end

  always_comb begin
    if (bus_addr == 4'd0)                     rd_mux = {3'b000, ctrl_q};
    else if (bus_addr == 4'd1)                rd_mux = field_out(3'd0, cal_cur, ctrl_q[2]);
    else if (bus_addr inside {[4'd2:4'd7]})   rd_mux = field_out(3'(bus_addr - 4'd1), snap_q, ctrl_q[2]);
    else if (bus_addr inside {[4'd8:4'd13]})  rd_mux = field_out(3'(bus_addr - 4'd8), al_q, ctrl_q[2]);
    else if (bus_addr == 4'd14)               rd_mux = trim_q[15:8];
    else                                      rd_mux = trim_q[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      trim_q  <= '0;
      al_q    <= '{yr: 7'd4, mon: 4'd1, day: 5'd1, hr: 5'd0, mn: 6'd0, sc: 6'd0, wd: 3'd0};
      snap_q  <= '{yr: 7'd0, mon: 4'd1, day: 5'd1, hr: 5'd0, mn: 6'd0, sc: 6'd0, wd: 3'd0};
      rdata_q <= '0;
      per_q   <= 1'b0;
      alm_q   <= 1'b0;
    end else begin
      per_q <= sec_tick && per_hit;
      alm_q <= sec_tick && ctrl_q[1] && al_match;
      if (bus_wr) begin
        if (bus_addr == 4'd0)                    ctrl_q <= bus_wdata[4:0];
        if (bus_addr inside {[4'd8:4'd13]})      al_q   <= set_f(al_q, 3'(bus_addr - 4'd8), al_val);
        if (bus_addr == 4'd14)                   trim_q[15:8] <= bus_wdata;
        if (bus_addr == 4'd15)                   trim_q[7:0]  <= bus_wdata;
      end
      if (bus_rd) begin
        rdata_q <= rd_mux;
        if (bus_addr == 4'd1) snap_q <= cal_cur;
      end
    end
  end

  assign bus_rdata      = rdata_q;
  assign periodic_pulse = per_q;
  assign alarm_pulse    = alm_q;
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      run,
  input logic      al_en,
  input logic      sec_tick,
  input logic      bus_wr,
  input logic      periodic_pulse,
  input logic      alarm_pulse,
  input rtc_time_t cur,
  input rtc_time_t al
);
  // R3: stopped clock with no write keeps the time
  p_frozen_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> $stable(cur));

  // R3: a second step moves seconds by one or wraps them
  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !bus_wr) |=> (cur.sc == 6'd0 || cur.sc == $past(cur.sc) + 6'd1));

  // R4 / R8: fields stay in their legal ranges
  p_field_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.sc < 6'd60 && cur.mn < 6'd60 && cur.hr < 5'd24 && cur.mon >= 4'd1 &&
     cur.mon <= 4'd12 && cur.day >= 5'd1 && cur.yr <= 7'd99 && cur.wd <= 3'd6));

  // R9: periodic pulse only follows a second boundary
  p_periodic_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |-> $past(sec_tick));

  // R10: alarm pulse implies enabled alarm and matching time
  p_alarm_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_pulse && !$past(bus_wr)) |-> ($past(al_en) && cur.sc == al.sc && cur.mn == al.mn &&
      cur.hr == al.hr && cur.day == al.day && cur.mon == al.mon && cur.yr == al.yr));
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .al_en(ctrl_q[1]), .sec_tick(sec_tick),
  .bus_wr(bus_wr), .periodic_pulse(periodic_pulse), .alarm_pulse(alarm_pulse),
  .cur(cal_cur), .al(al_q)
);

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic periodic_pulse, alarm_pulse;
  int checks = 0, errors = 0, per_cnt = 0, alm_cnt = 0;

  always #10 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(16), .TRIM_PERIOD_S(6), .TRIM_FIRST_S(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periodic_pulse(periodic_pulse), .alarm_pulse(alarm_pulse)
  );

  always @(posedge clk) begin
    if (periodic_pulse) per_cnt++;
    if (alarm_pulse) alm_cnt++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; per_cnt = 0; alm_cnt = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, $sformatf("addr %0d", a), int'(d), int'(exp));
  endtask

  task automatic pulses(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] yr, mo, dy, hr, mi, se);
    wr(4'd6, yr); wr(4'd5, mo); wr(4'd4, dy); wr(4'd3, hr); wr(4'd2, mi); wr(4'd1, se);
  endtask

  task automatic t_reset();
    rdchk("R1", 4'd0, 8'h00); rdchk("R1", 4'd1, 8'h00); rdchk("R1", 4'd3, 8'h00);
    rdchk("R1", 4'd4, 8'h01); rdchk("R1", 4'd5, 8'h01); rdchk("R1", 4'd6, 8'h00);
    rdchk("R1", 4'd7, 8'h00); rdchk("R1", 4'd8, 8'h00); rdchk("R1", 4'd11, 8'h01);
    rdchk("R1", 4'd12, 8'h01); rdchk("R1", 4'd13, 8'h04); rdchk("R1", 4'd14, 8'h00);
    check("R1", "pulses idle", per_cnt + alm_cnt, 0);
  endtask

  task automatic t_count_freeze();
    int p0;
    wr(4'd0, 8'h01); p0 = per_cnt;
    pulses(80);
    rdchk("R3", 4'd1, 8'h05); rdchk("R5", 4'd2, 8'h00);
    check("R9", "select 0 pulse count", per_cnt - p0, 5);
    pulses(8); wr(4'd0, 8'h00); pulses(100);
    rdchk("R3", 4'd1, 8'h05);
    wr(4'd0, 8'h01); pulses(7);
    rdchk("R3", 4'd1, 8'h05);
    pulses(1);
    rdchk("R3", 4'd1, 8'h06);
  endtask

  task automatic t_rollover();
    int p0;
    wr(4'd0, 8'h19);
    set_time(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); wr(4'd7, 8'h06);
    p0 = per_cnt; pulses(16);
    rdchk("R4", 4'd1, 8'h00); rdchk("R4", 4'd2, 8'h00); rdchk("R4", 4'd3, 8'h00);
    rdchk("R4", 4'd4, 8'h01); rdchk("R4", 4'd5, 8'h03); rdchk("R4", 4'd6, 8'h03);
    rdchk("R4", 4'd7, 8'h00);
    check("R9", "select 3 midnight", per_cnt - p0, 1);
    p0 = per_cnt; pulses(16);
    check("R9", "select 3 quiet", per_cnt - p0, 0);
    set_time(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulses(16);
    rdchk("R4", 4'd1, 8'h00); rdchk("R4", 4'd4, 8'h29); rdchk("R4", 4'd5, 8'h02);
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); pulses(16);
    rdchk("R4", 4'd1, 8'h00); rdchk("R4", 4'd6, 8'h00); rdchk("R4", 4'd5, 8'h01);
    rdchk("R4", 4'd4, 8'h01);
    wr(4'd0, 8'h09); wr(4'd1, 8'h58); p0 = per_cnt; pulses(32);
    check("R9", "select 1 count", per_cnt - p0, 1);
    wr(4'd0, 8'h11); wr(4'd2, 8'h58); wr(4'd1, 8'h59); p0 = per_cnt; pulses(16);
    check("R9", "select 2 no minute wrap", per_cnt - p0, 0);
    wr(4'd1, 8'h59); p0 = per_cnt; pulses(16);
    check("R9", "select 2 minute wrap", per_cnt - p0, 1);
  endtask

  task automatic t_hours();
    wr(4'd0, 8'h01); wr(4'd3, 8'h13); wr(4'd0, 8'h05);
    rdchk("R6", 4'd1, 8'h00); rdchk("R6", 4'd3, 8'h82);
    wr(4'd3, 8'h05); rdchk("R7", 4'd1, 8'h00); rdchk("R7", 4'd3, 8'h05);
    wr(4'd3, 8'h15); wr(4'd0, 8'h01);
    rdchk("R7", 4'd1, 8'h00); rdchk("R7", 4'd3, 8'h11);
    wr(4'd0, 8'h05); wr(4'd3, 8'h92); wr(4'd0, 8'h01);
    rdchk("R7", 4'd1, 8'h00); rdchk("R7", 4'd3, 8'h23);
    wr(4'd0, 8'h05); wr(4'd10, 8'h81);
    rdchk("R6", 4'd10, 8'h81);
    wr(4'd0, 8'h01); rdchk("R7", 4'd10, 8'h12);
    wr(4'd10, 8'h00);
  endtask

  task automatic t_fields();
    wr(4'd0, 8'hFF); rdchk("R2", 4'd0, 8'h1F);
    wr(4'd0, 8'h00);
    wr(4'd1, 8'hA5); rdchk("R8", 4'd1, 8'h25);
    wr(4'd2, 8'hC7); wr(4'd5, 8'h00);
    rdchk("R8", 4'd1, 8'h25); rdchk("R8", 4'd2, 8'h47); rdchk("R8", 4'd5, 8'h01);
  endtask

  task automatic t_alarm();
    int a0;
    wr(4'd0, 8'h03);
    set_time(8'h04, 8'h03, 8'h01, 8'h00, 8'h00, 8'h03);
    wr(4'd12, 8'h03); wr(4'd8, 8'h05);
    a0 = alm_cnt; pulses(16);
    check("R10", "before match", alm_cnt - a0, 0);
    pulses(16);
    rdchk("R10", 4'd1, 8'h05);
    check("R10", "on match", alm_cnt - a0, 1);
    pulses(16);
    check("R10", "after match", alm_cnt - a0, 1);
    wr(4'd0, 8'h01); wr(4'd1, 8'h04); a0 = alm_cnt; pulses(16);
    check("R10", "disabled", alm_cnt - a0, 0);
  endtask

  task automatic t_trim();
    do_reset();
    wr(4'd14, 8'h00); wr(4'd15, 8'h04); rdchk("R11", 4'd15, 8'h04);
    wr(4'd0, 8'h01);
    pulses(48); rdchk("R11", 4'd1, 8'h03);
    pulses(11); rdchk("R11", 4'd1, 8'h03);
    pulses(1);  rdchk("R11", 4'd1, 8'h04);
    pulses(16); rdchk("R11", 4'd1, 8'h05);
    pulses(64); rdchk("R11", 4'd1, 8'h09);
    pulses(11); rdchk("R11", 4'd1, 8'h09);
    pulses(1);  rdchk("R11", 4'd1, 8'h10);
    do_reset();
    wr(4'd14, 8'hFF); wr(4'd15, 8'hFC); wr(4'd0, 8'h01);
    pulses(48); rdchk("R11", 4'd1, 8'h03);
    pulses(19); rdchk("R11", 4'd1, 8'h03);
    pulses(1);  rdchk("R11", 4'd1, 8'h04);
  endtask

  task automatic t_snapshot();
    do_reset();
    wr(4'd0, 8'h01); wr(4'd2, 8'h10); wr(4'd1, 8'h59);
    rdchk("R12", 4'd1, 8'h59);
    pulses(16);
    rdchk("R12", 4'd2, 8'h10);
    rdchk("R12", 4'd1, 8'h00);
    rdchk("R12", 4'd2, 8'h11);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset();
    t_count_freeze();
    t_rollover();
    t_hours();
    t_fields();
    t_alarm();
    t_trim();
    t_snapshot();
    finish_run();
  end
endmodule